// File: doc/BRIEF.md
# Programmable Input Edge Synchronizer

This block conditions a bank of independent single-bit inputs before they reach a downstream logic-element selection mux. Each channel takes one raw input and a private 3-bit mode word. The mode word can invert the signal. It can replace the level with a one-clock pulse on each detected rising edge of the (possibly inverted) level. It can also choose whether the result goes straight to the output or first crosses a multi-flop synchronizer clocked by the block clock.

Because the polarity bit is applied before the detector, setting it turns a rising-edge detector into a falling-edge detector of the raw input. The detector clears itself: a pulse never lasts more than one clock, and no software action is needed to re-arm it. Changing a channel's mode word suppresses detection for one clock, so a polarity flip on a steady input does not produce a false pulse.

Top module: `edge_cond_bank`

## Requirements
- R1: The bank has N_CH channels (default 16). The mode word of channel i occupies cfg_i[3i+2:3i]: bit 3i is invert, bit 3i+1 is edge mode and bit 3i+2 is synchronized mode. Channel i drives dout_o[i].
- R2: The conditioned level is din XOR invert. With edge mode 0 and synchronized mode 0, dout equals that level combinationally, with no clock delay.
- R3: With edge mode 1, a pulse of 1 is produced after a rising clock edge whose sampled conditioned level is 1 when the level sampled at the previous edge was 0. With invert 0 this is a rising edge of din; with invert 1 it is a falling edge of din.
- R4: An edge-mode pulse lasts exactly one clock cycle even while the conditioned level stays at 1, and no further pulse occurs until the level has returned to 0 and risen again.
- R5: With synchronized mode 1, dout is the unsynchronized result delayed by exactly SYNC_STAGES (default 3) rising clock edges. A bypass level change is visible after the third edge, and an edge pulse is visible after the fourth edge counted from the input change.
- R6: With synchronized mode 0 and edge mode 1, the pulse appears on dout right after the detecting clock edge and is gone after the following edge.
- R7: At the first clock edge after a channel's mode word changes, that channel records the new conditioned level as history and produces no pulse. Flipping the invert bit on a steady input therefore yields no pulse.
- R8: A synchronous active-high reset clears every detector history, pulse and synchronizer flop to 0, so synchronized outputs read 0 during reset. After release, a steady level of 1 reappears after the third clock edge.
- R9: Channels are independent: stimulus on one channel does not change the output of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; all state updates on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| din_i | input | N_CH | Raw input of each channel |
| cfg_i | input | 3*N_CH | Per-channel mode words, 3 bits per channel |
| dout_o | output | N_CH | Conditioned output of each channel |

## Verification
Inputs change 2 ns after a rising edge. An asynchronous bypass output is due within that same cycle. An asynchronous edge pulse is due after the first edge and must be gone after the second. A synchronized bypass change is due after the third edge, and a synchronized edge pulse only after the fourth. Every scenario samples the output at each of the six cycles that follow a stimulus and compares it with a value worked out from the mode bits. Checking the cycle just before the due one, as well as the due cycle itself, pins the latency exactly. Reset release, mode-word changes and idle neighbouring channels are checked in the same cycle-by-cycle way.

// File: rtl/edge_cond_pkg.sv
package edge_cond_pkg;
   localparam int CFG_W = 3;

   typedef struct packed {
      logic sync_en;   // bit 2: pass through synchronizer
      logic edge_en;   // bit 1: use edge pulse instead of level
      logic invert;    // bit 0: invert raw input
   } chan_cfg_t;
endpackage

// File: rtl/ecb_edge_det.sv
module ecb_edge_det (
   input  logic clk_i,
   input  logic rst_i,
   input  logic lvl_i,
   input  logic cfg_chg_i,
   output logic pulse_o
);
   logic hist_q;
   logic pulse_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         hist_q  <= 1'b0;
         pulse_q <= 1'b0;
      end else if (cfg_chg_i) begin
         hist_q  <= lvl_i;
         pulse_q <= 1'b0;
      end else begin
         hist_q  <= lvl_i;
         pulse_q <= lvl_i & ~hist_q;
      end
   end

   assign pulse_o = pulse_q;

   AST_PULSE_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
      pulse_q |=> !pulse_q); // R4
   AST_PULSE_HAS_HIGH_LEVEL: assert property (@(posedge clk_i) disable iff (rst_i)
      pulse_q |-> hist_q); // R3
   AST_CFG_CHANGE_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
      cfg_chg_i |=> !pulse_q); // R7
endmodule

// File: rtl/ecb_sync_chain.sv
module ecb_sync_chain #(
   parameter int STAGES = 3
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic d_i,
   output logic q_o
);
   localparam int AGE_W = $clog2(STAGES + 1);

   if (STAGES < 2 || STAGES > 4) begin : g_bad_stages
      $error("ecb_sync_chain: STAGES must lie in 2..4");
   end

   logic [STAGES-1:0] stg_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) stg_q <= '0;
      else       stg_q <= {stg_q[STAGES-2:0], d_i};
   end

   assign q_o = stg_q[STAGES-1];

   // edges since reset release, saturating; lets the latency check start cleanly
   logic [AGE_W-1:0] age_q;
   always_ff @(posedge clk_i) begin
      if (rst_i)                         age_q <= '0;
      else if (age_q != AGE_W'(STAGES))  age_q <= age_q + 1'b1;
   end

   AST_SYNC_LATENCY: assert property (@(posedge clk_i) disable iff (rst_i)
      (age_q == AGE_W'(STAGES)) |-> (q_o == $past(d_i, STAGES))); // R5
endmodule

// File: rtl/ecb_channel.sv
module ecb_channel
   import edge_cond_pkg::*;
#(
   parameter int SYNC_STAGES = 3
) (
   input  logic      clk_i,
   input  logic      rst_i,
   input  logic      din_i,
   input  chan_cfg_t cfg_i,
   output logic      dout_o
);
   chan_cfg_t cfg_q;
   logic      lvl;
   logic      cfg_chg;
   logic      pulse;
   logic      pre_sync;
   logic      synced;

   always_ff @(posedge clk_i) begin
      if (rst_i) cfg_q <= '0;
      else       cfg_q <= cfg_i;
   end

   assign cfg_chg = (cfg_i != cfg_q);
   assign lvl     = din_i ^ cfg_i.invert;

   ecb_edge_det u_det (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .lvl_i     (lvl),
      .cfg_chg_i (cfg_chg),
      .pulse_o   (pulse)
   );

   assign pre_sync = cfg_i.edge_en ? pulse : lvl;

   ecb_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .d_i   (pre_sync),
      .q_o   (synced)
   );

   assign dout_o = cfg_i.sync_en ? synced : pre_sync;

   AST_BYPASS_NO_PULSE_WIDTH: assert property (@(posedge clk_i) disable iff (rst_i)
      (cfg_i.edge_en && !cfg_i.sync_en && dout_o && !cfg_chg) |=> (!dout_o || cfg_chg)); // R6
endmodule

// File: rtl/edge_cond_bank.sv
module edge_cond_bank
   import edge_cond_pkg::*;
#(
   parameter int N_CH        = 16,
   parameter int SYNC_STAGES = 3
) (
   input  logic                  clk_i,
   input  logic                  rst_i,
   input  logic [N_CH-1:0]       din_i,
   input  logic [N_CH*CFG_W-1:0] cfg_i,
   output logic [N_CH-1:0]       dout_o
);
   if (N_CH < 1 || N_CH > 64) begin : g_bad_nch
      $error("edge_cond_bank: N_CH must lie in 1..64");
   end

   for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
      ecb_channel #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
         .clk_i  (clk_i),
         .rst_i  (rst_i),
         .din_i  (din_i[ch]),
         .cfg_i  (chan_cfg_t'(cfg_i[ch*CFG_W +: CFG_W])),
         .dout_o (dout_o[ch])
      );
   end
endmodule

// File: tb/edge_cond_bank_tb_top.sv
module edge_cond_bank_tb_top;
   localparam int NCH = 16;
   localparam int CW  = 3;
   localparam int TCH = 3;   // channel under test

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [NCH-1:0]    din = '0;
   logic [NCH*CW-1:0] cfg = '0;
   logic [NCH-1:0]    dout;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   edge_cond_bank dut_i (
      .clk_i  (clk),
      .rst_i  (rst),
      .din_i  (din),
      .cfg_i  (cfg),
      .dout_o (dout)
   );

   task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic set_cfg(input int ch, input logic [2:0] c);
      cfg[ch*CW +: CW] = c;
   endtask

   // drive a new din value on the test channel and check six cycles of output
   task automatic apply_edge(input logic [2:0] code, input logic newv);
      logic oldl, newl, p, e;
      string req;
      oldl = din[TCH] ^ code[0];
      newl = newv ^ code[0];
      p    = newl & ~oldl;
      din[TCH] = newv;
      #1;
      for (int t = 0; t < 6; t++) begin
         if (t > 0) tick(1);
         if (!code[1]) begin
            e   = code[2] ? ((t >= 3) ? newl : oldl) : newl;
            req = code[2] ? "R5" : "R2";
         end else begin
            e   = code[2] ? ((t == 4) && p) : ((t == 1) && p);
            req = code[2] ? "R5" : ((t <= 1) ? "R6" : "R4");
         end
         chk(req, $sformatf("code=%0b din=%0b t=%0d", code, newv, t), {15'd0, dout[TCH]}, {15'd0, e});
      end
      chk("R9", $sformatf("other channels code=%0b", code), dout & ~(16'h1 << TCH), 16'h0);
   endtask

   task automatic run_code(input logic [2:0] code);
      din[TCH] = 1'b0;
      set_cfg(TCH, code);
      tick(5);
      apply_edge(code, 1'b1);   // R3: rising raw edge
      apply_edge(code, 1'b0);   // R3: falling raw edge
   endtask

   task automatic test_reset_state;
      cfg = {NCH{3'b100}};
      din = '1;
      tick(2);
      chk("R8", "sync outputs during reset", dout, 16'h0);
      cfg = '0;
      din = '0;
      rst = 1'b0;
      tick(5);
      chk("R8", "idle after release", dout, 16'h0);
   endtask

   task automatic test_cfg_change;
      din[TCH] = 1'b1;
      set_cfg(TCH, 3'b010);
      tick(5);
      chk("R7", "settled edge mode", {15'd0, dout[TCH]}, 16'h0);
      set_cfg(TCH, 3'b011);
      for (int t = 1; t <= 3; t++) begin
         tick(1);
         chk("R7", $sformatf("invert on t=%0d", t), {15'd0, dout[TCH]}, 16'h0);
      end
      set_cfg(TCH, 3'b010);   // level goes 0->1 only through the mode change
      for (int t = 1; t <= 3; t++) begin
         tick(1);
         chk("R7", $sformatf("invert off t=%0d", t), {15'd0, dout[TCH]}, 16'h0);
      end
      din[TCH] = 1'b0;
      set_cfg(TCH, 3'b000);
      tick(5);
   endtask

   task automatic test_mid_reset;
      din[TCH] = 1'b1;
      set_cfg(TCH, 3'b100);
      tick(5);
      chk("R5", "sync level before reset", {15'd0, dout[TCH]}, 16'h1);
      rst = 1'b1;
      tick(1);
      chk("R8", "cleared by reset", {15'd0, dout[TCH]}, 16'h0);
      rst = 1'b0;
      for (int t = 1; t <= 3; t++) begin
         tick(1);
         chk("R8", $sformatf("release t=%0d", t), {15'd0, dout[TCH]}, (t == 3) ? 16'h1 : 16'h0);
      end
      din[TCH] = 1'b0;
      set_cfg(TCH, 3'b000);
      tick(5);
   endtask

   task automatic test_top_channel;
      set_cfg(NCH - 1, 3'b001);
      #1;
      chk("R1", "channel 15 inverted bypass", dout, 16'h8000);
      set_cfg(NCH - 1, 3'b000);
      #1;
      chk("R1", "channel 15 restored", dout, 16'h0);
      tick(2);
   endtask

   initial begin
      @(posedge clk);
      #2;
      test_reset_state();
      for (int c = 0; c < 8; c++) run_code(3'(c));
      test_cfg_change();
      test_mid_reset();
      test_top_channel();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog all requirements actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule